// File: doc/BRIEF.md
# SONET Transmit Overhead Error Injector

This block sits in the byte-wide transmit path of an STS-3/STM-1 framer, after frame assembly. Each byte comes with row, column and STS-1 position markers. The block passes the stream through with one register of latency. On demand it replaces chosen section and line overhead bytes so that a far-end receiver can be exercised. There are three kinds of corruption:

- **Framing errors.** A burst of frames carries an errored A2 byte. A burst is started by a rising edge on an asynchronous trigger pin.
- **Pointer corruption.** The H1/H2 bytes are corrupted per STS-1, or once for the whole pointer in concatenated mode. Either an out-of-range offset or a persistent new-data flag is sent.
- **APS babble.** The APS bytes K1/K2 carry a value that changes every frame.

A small state machine controls the framing-error bursts. Its states are `BST_IDLE`, `BST_ARMED` and `BST_BURST`, and its transitions are:

- **ARM** (IDLE to ARMED): a synchronised trigger edge arrives while the programmed count is non-zero. The count is latched.
- **LAUNCH** (ARMED to BURST): the next frame start. The remaining-frame counter is loaded.
- **STEP** (BURST to BURST): each later frame start while more than one frame remains. The counter is decremented.
- **FINISH** (BURST to IDLE): the frame start at which one frame remains.

Every other condition holds the current state. A free-running 13-bit LFSR advances at every frame start and supplies the babble values.

Top module: `sonet_oh_err_inject`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `out_data` is the substituted byte one clock after its input. Reset drives both outputs to 0. With all controls at 0, every byte leaves unchanged.
- R2: A frame start is a valid byte at row 0, column 0, STS 0. A synchronised rising edge on `err_trig_async` with `cfg_a2_count` = N (1 to 31) makes exactly N consecutive frames carry 0xD7 in every A2 byte (row 0, column 1, any STS). The first such frame is the one beginning at the next frame start.
- R3: A trigger edge seen while `cfg_a2_count` is 0 inserts no errored A2 byte.
- R4: A trigger edge that arrives while a burst is armed or running is ignored. The burst length stays as first programmed.
- R5: With `cfg_ndf_sel` = 0 and enable bit i of `cfg_ptr_en` set, the pointer bytes of STS i are replaced. H1 (row 3, column 0) becomes {0110, input bits 3:2, 11}. H2 (row 3, column 1) becomes 0xFF, giving offset 1023.
- R6: With `cfg_ndf_sel` = 1 and bit i set, H1 of STS i becomes {1001, input bits 3:0}. H2 passes unchanged.
- R7: With `cfg_au4_mode` = 1, only bit 0 of `cfg_ptr_en` has effect, and only the STS 0 H1/H2 bytes are replaced. The STS 1 and STS 2 H1/H2 bytes pass unchanged.
- R8: With `cfg_babble_en` = 1, the APS value is replaced. K1 (row 4, column 1, STS 0) takes all 8 bits of a 13-bit value. K2 (row 4, column 2, STS 0) takes bits 7:3 from the remaining 5 bits of that value, and its bits 2:0 pass unchanged. The 13-bit value is never zero and differs between consecutive frames.
- R9: Every byte at a position not named in R2, R5 to R8 passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Outgoing frame byte |
| in_row | input | 4 | Row of the byte, 0 to 8 |
| in_col | input | 7 | Column within its STS-1, 0 to 89 |
| in_sts | input | 2 | STS-1 interleave index, 0 to 2 |
| cfg_a2_count | input | 5 | Errored frames per trigger edge |
| cfg_babble_en | input | 1 | APS babble enable |
| cfg_ptr_en | input | 3 | Pointer corruption enable, one bit per STS-1 |
| cfg_ndf_sel | input | 1 | 0: invalid offset, 1: continuous new-data flag |
| cfg_au4_mode | input | 1 | Concatenated mode, bit 0 governs the single pointer |
| err_trig_async | input | 1 | Asynchronous error-insert trigger |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Frame byte after substitution |

## Verification
The assertions rely on three assumptions about the inputs:

- Position markers are legal (row at most 8, STS at most 2).
- Control fields change only between frames.
- The trigger pin is held high or low for several clocks, so that the two-stage synchroniser delay is small next to a frame.

The stimulus follows these assumptions:

- Every trigger pulse is raised at row 5 and held for about ten bytes. This keeps the synchroniser latency well away from any frame start or A2 byte.
- Configuration is changed only between whole frames.
- Each frame carries two idle cycles at row 6, so the valid path is exercised without disturbing the overhead rows.

// File: rtl/sonet_oh_pkg.sv
package sonet_oh_pkg;

    localparam int ROW_W = 4;
    localparam int COL_W = 7;
    localparam int STS_W = 2;

    localparam logic [7:0]       A2_NOMINAL  = 8'h28;
    localparam logic [7:0]       A2_ERRORED  = ~A2_NOMINAL;

    localparam logic [ROW_W-1:0] ROW_FRAMING = 4'd0;
    localparam logic [ROW_W-1:0] ROW_POINTER = 4'd3;
    localparam logic [ROW_W-1:0] ROW_APS     = 4'd4;

    localparam logic [COL_W-1:0] COL_FIRST   = 7'd0;
    localparam logic [COL_W-1:0] COL_SECOND  = 7'd1;
    localparam logic [COL_W-1:0] COL_THIRD   = 7'd2;

    localparam logic [3:0]       NDF_NORMAL   = 4'b0110;
    localparam logic [3:0]       NDF_ASSERTED = 4'b1001;
    localparam logic [9:0]       PTR_INVALID  = 10'd1023;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_ARMED = 2'd1,
        BST_BURST = 2'd2
    } burst_state_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [STS_W-1:0] sts;
    } frame_pos_t;

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // synchroniser chain, stage 0 samples the pin
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= trig_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign trig_rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/a2_burst_ctrl.sv
module a2_burst_ctrl
    import sonet_oh_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_rise,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] cfg_count,
    output burst_state_t     state_o,
    output logic [CNT_W-1:0] remain_o,
    output logic             corrupt_a2
);

    localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(1);

    burst_state_t     state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic [CNT_W-1:0] latch_q, latch_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= BST_IDLE;
            remain_q <= '0;
            latch_q  <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            latch_q  <= latch_d;
        end
    end

    // transitions: ARM, LAUNCH, STEP, FINISH
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        latch_d  = latch_q;
        unique case (state_q)
            BST_IDLE: begin
                if (edge_rise && (cfg_count != '0)) begin
                    state_d = BST_ARMED;
                    latch_d = cfg_count;
                end
            end
            BST_ARMED: begin
                if (frame_start) begin
                    state_d  = BST_BURST;
                    remain_d = latch_q;
                end
            end
            BST_BURST: begin
                if (frame_start) begin
                    if (remain_q == LAST_FRAME) begin
                        state_d  = BST_IDLE;
                        remain_d = '0;
                    end else begin
                        remain_d = remain_q - LAST_FRAME;
                    end
                end
            end
            default: begin
                state_d  = BST_IDLE;
                remain_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        corrupt_a2 = (state_q == BST_BURST);
        state_o    = state_q;
        remain_o   = remain_q;
    end

endmodule

// File: rtl/aps_babble_gen.sv
module aps_babble_gen #(
    parameter int              APS_W    = 13,
    parameter logic [APS_W-1:0] TAP_MASK = 13'h100D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [APS_W-1:0] value_o
);

    localparam logic [APS_W-1:0] SEED = APS_W'(1);

    logic [APS_W-1:0] lfsr_q;
    logic             feedback;

    assign feedback = ^(lfsr_q & TAP_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lfsr_q <= SEED;
        else if (advance) lfsr_q <= {lfsr_q[APS_W-2:0], feedback};
    end

    assign value_o = lfsr_q;

endmodule

// File: rtl/oh_byte_sub.sv
module oh_byte_sub
    import sonet_oh_pkg::*;
#(
    parameter int NUM_STS = 3,
    parameter int APS_W   = 13
) (
    input  logic [7:0]         data_i,
    input  frame_pos_t         pos_i,
    input  logic               a2_err_i,
    input  logic               babble_en_i,
    input  logic [APS_W-1:0]   babble_val_i,
    input  logic [NUM_STS-1:0] ptr_en_i,
    input  logic               ndf_sel_i,
    input  logic               au4_i,
    output logic [7:0]         data_o
);

    localparam int K1_BITS = 8;
    localparam int K2_BITS = APS_W - K1_BITS;

    logic [NUM_STS-1:0] sts_sel;
    logic [NUM_STS-1:0] sts_ptr_on;
    logic               ptr_hit;
    logic               first_sts;
    logic               is_a2, is_h1, is_h2, is_k1, is_k2;

    // per-STS pointer enable; concatenated mode keeps only the first
    generate
        for (genvar i = 0; i < NUM_STS; i++) begin : g_sts
            assign sts_sel[i] = (pos_i.sts == STS_W'(i));
            if (i == 0) begin : g_lead
                assign sts_ptr_on[i] = ptr_en_i[i];
            end else begin : g_tail
                assign sts_ptr_on[i] = ptr_en_i[i] & ~au4_i;
            end
        end
    endgenerate

    assign ptr_hit   = |(sts_sel & sts_ptr_on);
    assign first_sts = sts_sel[0];

    always_comb begin
        is_a2 = (pos_i.row == ROW_FRAMING) && (pos_i.col == COL_SECOND);
        is_h1 = (pos_i.row == ROW_POINTER) && (pos_i.col == COL_FIRST);
        is_h2 = (pos_i.row == ROW_POINTER) && (pos_i.col == COL_SECOND);
        is_k1 = (pos_i.row == ROW_APS) && (pos_i.col == COL_SECOND) && first_sts;
        is_k2 = (pos_i.row == ROW_APS) && (pos_i.col == COL_THIRD)  && first_sts;
    end

    always_comb begin
        data_o = data_i;
        if (is_a2 && a2_err_i) begin
            data_o = A2_ERRORED;
        end
        if (is_h1 && ptr_hit) begin
            if (ndf_sel_i) data_o = {NDF_ASSERTED, data_i[3:0]};
            else           data_o = {NDF_NORMAL, data_i[3:2], PTR_INVALID[9:8]};
        end
        if (is_h2 && ptr_hit && !ndf_sel_i) begin
            data_o = PTR_INVALID[7:0];
        end
        if (is_k1 && babble_en_i) begin
            data_o = babble_val_i[APS_W-1 -: K1_BITS];
        end
        if (is_k2 && babble_en_i) begin
            data_o = {babble_val_i[K2_BITS-1:0], data_i[7-K2_BITS:0]};
        end
    end

endmodule

// File: rtl/sonet_oh_err_inject.sv
module sonet_oh_err_inject
    import sonet_oh_pkg::*;
#(
    parameter int NUM_STS     = 3,
    parameter int CNT_W       = 5,
    parameter int APS_W       = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [COL_W-1:0]   in_col,
    input  logic [STS_W-1:0]   in_sts,
    input  logic [CNT_W-1:0]   cfg_a2_count,
    input  logic               cfg_babble_en,
    input  logic [NUM_STS-1:0] cfg_ptr_en,
    input  logic               cfg_ndf_sel,
    input  logic               cfg_au4_mode,
    input  logic               err_trig_async,
    output logic               out_valid,
    output logic [7:0]         out_data
);

    frame_pos_t       pos;
    logic             frame_start;
    logic             trig_rise;
    logic             a2_corrupt;
    burst_state_t     burst_state;
    logic [CNT_W-1:0] burst_remain;
    logic [APS_W-1:0] babble_val;
    logic [7:0]       sub_data;

    assign pos = '{row: in_row, col: in_col, sts: in_sts};
    assign frame_start = in_valid && (in_row == ROW_FRAMING)
                         && (in_col == COL_FIRST) && (in_sts == '0);

    trig_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (err_trig_async),
        .trig_rise  (trig_rise)
    );

    a2_burst_ctrl #(
        .CNT_W (CNT_W)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_rise   (trig_rise),
        .frame_start (frame_start),
        .cfg_count   (cfg_a2_count),
        .state_o     (burst_state),
        .remain_o    (burst_remain),
        .corrupt_a2  (a2_corrupt)
    );

    aps_babble_gen #(
        .APS_W (APS_W)
    ) u_babble (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (frame_start),
        .value_o (babble_val)
    );

    oh_byte_sub #(
        .NUM_STS (NUM_STS),
        .APS_W   (APS_W)
    ) u_sub (
        .data_i       (in_data),
        .pos_i        (pos),
        .a2_err_i     (a2_corrupt),
        .babble_en_i  (cfg_babble_en),
        .babble_val_i (babble_val),
        .ptr_en_i     (cfg_ptr_en),
        .ndf_sel_i    (cfg_ndf_sel),
        .au4_i        (cfg_au4_mode),
        .data_o       (sub_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= sub_data;
        end
    end

endmodule

// File: rtl/sonet_oh_err_inject_chk.sv
module sonet_oh_err_inject_chk
    import sonet_oh_pkg::*;
#(
    parameter int NUM_STS = 3,
    parameter int CNT_W   = 5,
    parameter int APS_W   = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [COL_W-1:0]   in_col,
    input  logic [STS_W-1:0]   in_sts,
    input  logic [CNT_W-1:0]   cfg_a2_count,
    input  logic               cfg_babble_en,
    input  logic [NUM_STS-1:0] cfg_ptr_en,
    input  logic               cfg_ndf_sel,
    input  logic               cfg_au4_mode,
    input  logic               out_valid,
    input  logic [7:0]         out_data,
    input  burst_state_t       burst_state,
    input  logic [CNT_W-1:0]   burst_remain,
    input  logic               trig_rise,
    input  logic               frame_start,
    input  logic [APS_W-1:0]   babble_val
);

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_babble_en && cfg_ptr_en == '0 && burst_state != BST_BURST)
        |=> out_data == $past(in_data));

    assert_a2_errored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_row == ROW_FRAMING && in_col == COL_SECOND && burst_state == BST_BURST)
        |=> out_data == A2_ERRORED);

    assert_armed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_state == BST_ARMED && !frame_start) |=> burst_state == BST_ARMED);

    assert_remain_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_state == BST_BURST) |-> burst_remain != '0);

    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_state == BST_IDLE && trig_rise && cfg_a2_count == '0) |=> burst_state == BST_IDLE);

    assert_edge_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_state == BST_BURST && trig_rise && !frame_start)
        |=> (burst_state == BST_BURST) && $stable(burst_remain));

    assert_ndf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_row == ROW_POINTER && in_col == COL_FIRST && in_sts == '0
         && cfg_ptr_en[0] && cfg_ndf_sel)
        |=> out_data[7:4] == NDF_ASSERTED);

    assert_au4_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_au4_mode && in_row == ROW_POINTER && in_sts != '0
         && (in_col == COL_FIRST || in_col == COL_SECOND))
        |=> out_data == $past(in_data));

    assert_babble_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> babble_val != '0);

    assert_k2_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_babble_en && in_row == ROW_APS && in_col == COL_THIRD && in_sts == '0)
        |=> out_data[2:0] == $past(in_data[2:0]));

    assert_other_rows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_row != ROW_FRAMING && in_row != ROW_POINTER && in_row != ROW_APS)
        |=> out_data == $past(in_data));

endmodule

bind sonet_oh_err_inject sonet_oh_err_inject_chk #(
    .NUM_STS (NUM_STS),
    .CNT_W   (CNT_W),
    .APS_W   (APS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_row        (in_row),
    .in_col        (in_col),
    .in_sts        (in_sts),
    .cfg_a2_count  (cfg_a2_count),
    .cfg_babble_en (cfg_babble_en),
    .cfg_ptr_en    (cfg_ptr_en),
    .cfg_ndf_sel   (cfg_ndf_sel),
    .cfg_au4_mode  (cfg_au4_mode),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .burst_state   (burst_state),
    .burst_remain  (burst_remain),
    .trig_rise     (trig_rise),
    .frame_start   (frame_start),
    .babble_val    (babble_val)
);

// File: tb/tb_sonet_oh_err_inject.sv
module tb_sonet_oh_err_inject;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [3:0] in_row = '0;
    logic [6:0] in_col = '0;
    logic [1:0] in_sts = '0;
    logic [4:0] cfg_a2_count = '0;
    logic       cfg_babble_en = 1'b0;
    logic [2:0] cfg_ptr_en = '0;
    logic       cfg_ndf_sel = 1'b0;
    logic       cfg_au4_mode = 1'b0;
    logic       trig = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    sonet_oh_err_inject dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_row         (in_row),
        .in_col         (in_col),
        .in_sts         (in_sts),
        .cfg_a2_count   (cfg_a2_count),
        .cfg_babble_en  (cfg_babble_en),
        .cfg_ptr_en     (cfg_ptr_en),
        .cfg_ndf_sel    (cfg_ndf_sel),
        .cfg_au4_mode   (cfg_au4_mode),
        .err_trig_async (trig),
        .out_valid      (out_valid),
        .out_data       (out_data)
    );

    always #5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    run = 1'b0;
    int    a2_hits = 0;
    int    k_diffs = 0;
    int    last_k = -1;
    int    k_hi = 0;

    // reference model state
    int    m_state = 0;     // 0 idle, 1 armed, 2 burst
    int    m_rem = 0;
    int    m_cnt = 0;
    bit    m_trig_prev = 1'b0;
    bit    e_valid = 1'b0;
    logic [7:0] e_data = '0;
    logic [7:0] e_mask = 8'hFF;
    int    e_kind = 0;      // 0 plain, 1 A2, 2 K1 babble, 3 K2 babble, 4 K2 plain
    string e_tag = "R9";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // behavioural model, evaluated on the inputs present at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_cnt = 0; m_trig_prev = 1'b0;
            e_valid = 1'b0; e_kind = 0;
        end else begin
            if (trig && !m_trig_prev && m_state == 0 && cfg_a2_count != 0) begin
                m_state = 1;
                m_cnt = int'(cfg_a2_count);
            end
            m_trig_prev = trig;
            e_valid = in_valid;
            e_data = in_data;
            e_mask = 8'hFF;
            e_kind = 0;
            e_tag = "R9";
            if (in_valid) begin
                if (in_row == 0 && in_col == 0 && in_sts == 0) begin
                    if (m_state == 1) begin
                        m_state = 2; m_rem = m_cnt;
                    end else if (m_state == 2) begin
                        if (m_rem == 1) m_state = 0;
                        else m_rem = m_rem - 1;
                    end
                end
                if (in_row == 0 && in_col == 1) begin
                    e_kind = 1; e_tag = "R2";
                    if (m_state == 2) e_data = 8'hD7;
                end
                if (in_row == 3 && (in_col == 0 || in_col == 1)) begin
                    bit on;
                    e_tag = cfg_au4_mode ? "R7" : (cfg_ndf_sel ? "R6" : "R5");
                    on = cfg_au4_mode ? (in_sts == 0 && cfg_ptr_en[0]) : cfg_ptr_en[in_sts];
                    if (on) begin
                        if (!cfg_ndf_sel)
                            e_data = (in_col == 0) ? {4'b0110, in_data[3:2], 2'b11} : 8'hFF;
                        else if (in_col == 0)
                            e_data = {4'b1001, in_data[3:0]};
                    end
                end
                if (in_row == 4 && in_sts == 0 && in_col == 1 && cfg_babble_en) begin
                    e_kind = 2; e_tag = "R8"; e_mask = 8'h00;
                end
                if (in_row == 4 && in_sts == 0 && in_col == 2) begin
                    e_tag = "R8";
                    if (cfg_babble_en) begin e_kind = 3; e_mask = 8'h07; end
                    else e_kind = 4;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            chk(out_valid == e_valid, "R1 valid", int'(out_valid), int'(e_valid));
            if (e_valid) begin
                chk(((out_data ^ e_data) & e_mask) == 8'h00, e_tag, int'(out_data), int'(e_data));
                if (e_kind == 1 && out_data == 8'hD7) a2_hits++;
                if (e_kind == 2) k_hi = int'(out_data);
                if (e_kind == 3) begin
                    int v;
                    v = (k_hi << 5) | int'(out_data[7:3]);
                    chk(v != 0, "R8 nonzero", v, 1);
                    if (last_k >= 0) begin
                        chk(v != last_k, "R8 changes", v, last_k);
                        k_diffs++;
                    end
                    last_k = v;
                end
                if (e_kind == 4) last_k = -1;
            end
        end
    end

    task automatic send_byte(input int r, input int c, input int s);
        @(negedge clk);
        in_valid = 1'b1;
        in_row = 4'(r);
        in_col = 7'(c);
        in_sts = 2'(s);
        if (r == 0 && c == 0) in_data = 8'hF6;
        else if (r == 0 && c == 1) in_data = 8'h28;
        else in_data = 8'($urandom);
    endtask

    task automatic send_frame(input bit do_trig);
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 6; c++) begin
                for (int s = 0; s < 3; s++) begin
                    if (r == 6 && c == 0 && s == 0) begin
                        repeat (2) begin
                            @(negedge clk);
                            in_valid = 1'b0;
                            in_data = 8'($urandom);
                        end
                    end
                    if (do_trig && r == 5 && c == 0 && s == 0) trig = 1'b1;
                    if (r == 5 && c == 3 && s == 0) trig = 1'b0;
                    send_byte(r, c, s);
                end
            end
        end
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0 && out_data == 8'h00, "R1 reset", int'({out_valid, out_data}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;

        // R1 / R9: controls idle, stream untouched
        repeat (3) send_frame(1'b0);

        // R2 and R4: three-frame burst, second edge inside the burst
        cfg_a2_count = 5'd3;
        base = a2_hits;
        send_frame(1'b1);
        send_frame(1'b0);
        send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        chk(a2_hits - base == 9, "R4 burst length kept", a2_hits - base, 9);

        // R3: zero count
        cfg_a2_count = 5'd0;
        base = a2_hits;
        send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        chk(a2_hits - base == 0, "R3 zero count", a2_hits - base, 0);

        // R2: single frame
        cfg_a2_count = 5'd1;
        base = a2_hits;
        send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        chk(a2_hits - base == 3, "R2 single", a2_hits - base, 3);

        // R2: maximum count
        cfg_a2_count = 5'd31;
        base = a2_hits;
        send_frame(1'b1);
        repeat (33) send_frame(1'b0);
        chk(a2_hits - base == 93, "R2 max count", a2_hits - base, 93);
        cfg_a2_count = 5'd0;

        // R5 / R6 / R7: pointer corruption modes
        cfg_ptr_en = 3'b101;
        repeat (2) send_frame(1'b0);
        cfg_ndf_sel = 1'b1;
        repeat (2) send_frame(1'b0);
        cfg_ndf_sel = 1'b0;
        cfg_au4_mode = 1'b1;
        cfg_ptr_en = 3'b110;
        send_frame(1'b0);
        cfg_ptr_en = 3'b011;
        send_frame(1'b0);
        cfg_ndf_sel = 1'b1;
        send_frame(1'b0);
        cfg_au4_mode = 1'b0;
        cfg_ndf_sel = 1'b0;
        cfg_ptr_en = 3'b000;
        send_frame(1'b0);

        // R8: babble
        cfg_babble_en = 1'b1;
        repeat (5) send_frame(1'b0);
        cfg_babble_en = 1'b0;
        send_frame(1'b0);
        chk(k_diffs >= 4, "R8 consecutive values", k_diffs, 4);

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule